// File: doc/BRIEF.md
# Periodic Word-Inversion Error Injector

This block drives a 16-bit transmit data port with a continuous pseudo-random word stream. On command it corrupts that stream on purpose: for a single clock it sends the bitwise complement of the word that would have gone out. It repeats this a programmed number of times, with a programmed number of clean words between the corrupted ones. A downstream checker regenerates the pseudo-random sequence, so every inverted word shows up there as a detectable error. That lets a latency measurement pair each corrupted transmit word with its detection on the receive side.

A one-cycle send-event pulse marks each corrupted word in the exact cycle it is on the port, so a timestamp unit can latch the transmit time. Control is a small set of signals: a repetition count, a spacing, and a one-cycle start strobe. A live remaining-injection count can be read back. When the burst is finished the block disarms itself and the clean stream simply continues.

Top module: `wfi_word_flip_injector`

## Requirements
- R1: Each injection replaces the outgoing word with its bitwise complement (all 16 bits inverted) for exactly one clock. Every other cycle carries the unmodified generator word.
- R2: A burst accepted with count N (16-bit `cfg_count`) produces exactly N inverted words.
- R3: With spacing G (16-bit `cfg_gap`), exactly G clean words are sent between consecutive inverted words. Exactly G clean words are also sent after the start cycle before the first inverted word. Counting clock edges from the edge that samples `start` as edge 0, the inverted words follow edges k*(G+1), for k = 1..N.
- R4: `start` is sampled as a one-cycle strobe. It is accepted only when the block is idle (remaining count zero) and `cfg_count` is nonzero. `cfg_count` and `cfg_gap` are captured at that edge, and later changes to them do not affect a running burst.
- R5: `remain` is 0 after reset. It shows N in the cycle after an accepted start. It decrements by one in the same cycle as each inverted word.
- R6: The block is active exactly while `remain` is nonzero. After the last inverted word, `remain` is 0 and the stream stays uninverted until a new start.
- R7: `send_evt` is 1 exactly in the cycles in which `tx_word` carries an inverted word.
- R8: A start with `cfg_count` equal to 0 performs no injection and leaves `remain` at 0.
- R9: A start strobe received while a burst is active is ignored, whatever count and spacing accompany it. The running burst keeps its original schedule.
- R10: The generator is PRBS-15 (x^15 + x^14 + 1) with an all-ones seed at reset. Per clock it advances 16 steps, where new bit = s[14] XOR s[13], shifted in at s[0]. The 16 new bits form the word, first bit in bit 15. `tx_word` is 0 in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_count | input | 16 | Number of injections for the next burst |
| cfg_gap | input | 16 | Clean words between injections |
| start | input | 1 | One-cycle start strobe |
| tx_word | output | 16 | Word to the transmit data port |
| send_evt | output | 1 | High in the cycle of an inverted word |
| remain | output | 16 | Injections still to be performed |

## Verification
Every combination of counts 0 to 4 and spacings 0 to 3 is run. A spacing of 0 checks back-to-back inversions, where no clean word sits between two corrupted ones. Count 0 tells an ignored start apart from an accepted one. The larger pairs expose off-by-one errors in the first interval or in the final decrement. Restarts are issued in the middle of a burst with different configuration values, and changes are made after a start, to separate a discarded strobe from a reloaded schedule. Each cycle, the transmit word is compared against an independent PRBS model of the expected inversion mask.

// File: rtl/wfi_pkg.sv
package wfi_pkg;
    localparam int WORD_W = 16;
    localparam int CNT_W  = 16;

    typedef struct packed {
        logic [CNT_W-1:0] remain;
        logic [CNT_W-1:0] tmr;
        logic [CNT_W-1:0] gap;
        logic             flip;
    } burst_state_t;
endpackage

// File: rtl/wfi_prbs_feed.sv
module wfi_prbs_feed #(
    parameter int WORD_W  = 16,
    parameter int PRBS_LEN = 15,
    parameter int PRBS_TAP = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic [PRBS_LEN-1:0] lfsr;
        logic [WORD_W-1:0]   word;
    } feed_t;

    feed_t st_d, st_q;

    always_comb begin
        logic [PRBS_LEN-1:0] s;
        logic                nb;
        s    = st_q.lfsr;
        st_d = st_q;
        for (int i = 0; i < WORD_W; i++) begin
            nb = s[PRBS_LEN-1] ^ s[PRBS_TAP-1];
            s  = {s[PRBS_LEN-2:0], nb};
            st_d.word[WORD_W-1-i] = nb;
        end
        st_d.lfsr = s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lfsr <= '1;
            st_q.word <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.word;
endmodule

// File: rtl/wfi_burst_ctrl.sv
module wfi_burst_ctrl
    import wfi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [CNT_W-1:0] cfg_gap,
    input  logic             start,
    output logic             flip,
    output logic [CNT_W-1:0] remain
);
    burst_state_t st_d, st_q;
    logic         active;

    assign active = (st_q.remain != '0);

    always_comb begin
        st_d      = st_q;
        st_d.flip = 1'b0;
        if (!active) begin
            if (start && (cfg_count != '0)) begin
                st_d.remain = cfg_count;
                st_d.tmr    = cfg_gap;
                st_d.gap    = cfg_gap;
            end
        end else if (st_q.tmr == '0) begin
            st_d.flip   = 1'b1;
            st_d.remain = st_q.remain - 1'b1;
            st_d.tmr    = st_q.gap;
        end else begin
            st_d.tmr = st_q.tmr - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flip   = st_q.flip;
    assign remain = st_q.remain;

    AST_FLIP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && st_q.tmr == '0) |=> (flip && remain == $past(remain) - 1'b1)); // R5
    AST_ZERO_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && start && cfg_count == '0) |=> (remain == '0 && !flip)); // R8
    AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && start) |=> (remain <= $past(remain))); // R9
    AST_LAST_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (flip && remain == '0) |=> !flip); // R6
endmodule

// File: rtl/wfi_word_flip_injector.sv
module wfi_word_flip_injector #(
    parameter int WORD_W   = wfi_pkg::WORD_W,
    parameter int CNT_W    = wfi_pkg::CNT_W,
    parameter int PRBS_LEN = 15,
    parameter int PRBS_TAP = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [CNT_W-1:0]  cfg_gap,
    input  logic              start,
    output logic [WORD_W-1:0] tx_word,
    output logic              send_evt,
    output logic [CNT_W-1:0]  remain
);
    logic [WORD_W-1:0] prbs_word;
    logic              flip;

    wfi_prbs_feed #(
        .WORD_W  (WORD_W),
        .PRBS_LEN(PRBS_LEN),
        .PRBS_TAP(PRBS_TAP)
    ) feed_i (
        .clk  (clk),
        .rst_n(rst_n),
        .word (prbs_word)
    );

    wfi_burst_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_count(cfg_count),
        .cfg_gap  (cfg_gap),
        .start    (start),
        .flip     (flip),
        .remain   (remain)
    );

    assign tx_word  = prbs_word ^ {WORD_W{flip}};
    assign send_evt = flip;

    AST_EVT_NEEDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        send_evt |-> $past(remain) != '0); // R7
endmodule

// File: tb/wfi_word_flip_injector_tb.sv
module wfi_word_flip_injector_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_count = '0;
    logic [15:0] cfg_gap = '0;
    logic        start = 1'b0;
    logic [15:0] tx_word;
    logic        send_evt;
    logic [15:0] remain;

    int vectors = 0;
    int errors  = 0;
    int edge_n  = 0;
    bit done    = 1'b0;

    logic [14:0] ref_s;
    logic [15:0] ref_w;

    always #(CLK_PERIOD/2) clk = ~clk;

    wfi_word_flip_injector dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_count(cfg_count), .cfg_gap(cfg_gap),
        .start(start), .tx_word(tx_word), .send_evt(send_evt), .remain(remain)
    );

    // R10 reference stream, built from the stated polynomial and bit order
    always @(posedge clk) begin
        edge_n <= edge_n + 1;
        if (!rst_n) begin
            ref_s <= '1;
            ref_w <= '0;
        end else begin
            logic [14:0] s;
            logic [15:0] w;
            logic        b;
            s = ref_s;
            for (int i = 0; i < 16; i++) begin
                b = s[14] ^ s[13];
                s = {s[13:0], b};
                w[15-i] = b;
            end
            ref_s <= s;
            ref_w <= w;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at edge %0d: actual %h expected %h", req, edge_n, act, exp);
        end
    endtask

    // Run one burst; restart_d >= 0 pulses start again at that offset with other config
    task automatic run_burst(input int cnt, input int gap, input int restart_d,
                             input int alt_cnt, input int alt_gap);
        int s;
        int per;
        int len;
        per = gap + 1;
        len = cnt * per + 4;
        cfg_count = 16'(cnt);
        cfg_gap   = 16'(gap);
        start     = 1'b1;
        s = edge_n + 1;
        @(negedge clk);
        start = 1'b0;
        // R4: change configuration after the start is taken
        cfg_count = 16'(alt_cnt);
        cfg_gap   = 16'(alt_gap);
        for (int i = 0; i <= len; i++) begin
            int  d;
            bit  fire;
            int  rexp;
            d    = edge_n - s;
            fire = (cnt != 0) && (d > 0) && (d % per == 0) && (d / per <= cnt);
            rexp = (cnt == 0 || d / per >= cnt) ? 0 : cnt - d / per;
            check(cnt == 0 ? "R8 word" : "R1/R2/R3 word", 32'(tx_word), 32'(ref_w ^ {16{fire}}));
            check("R7 send_evt", 32'(send_evt), 32'(fire));
            check(restart_d >= 0 ? "R9 remain" : "R5/R6 remain", 32'(remain), 32'(rexp));
            if (restart_d >= 0 && d == restart_d && d / per < cnt) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R5 reset remain", 32'(remain), 32'd0);
        check("R10 reset word", 32'(tx_word), 32'd0);
        check("R7 reset evt", 32'(send_evt), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 first word", 32'(tx_word), 32'(ref_w));
        repeat (2) @(negedge clk);
        // R2 R3 sweep over count and spacing
        for (int c = 0; c <= 4; c++)
            for (int g = 0; g <= 3; g++)
                run_burst(c, g, -1, 7, 5);
        // R9: restarts while active
        run_burst(3, 2, 2, 9, 0);
        run_burst(2, 0, 1, 5, 3);
        run_burst(4, 1, 5, 1, 1);
        // R8 with a nonzero gap, then a longer burst
        run_burst(0, 6, -1, 0, 0);
        run_burst(6, 5, -1, 2, 2);
        // R6: stream clean after completion
        for (int i = 0; i < 8; i++) begin
            check("R6 idle word", 32'(tx_word), 32'(ref_w));
            check("R6 idle remain", 32'(remain), 32'd0);
            @(negedge clk);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule